// File: doc/BRIEF.md
# Streak-Demoting DRAM Request Arbiter

This block arbitrates memory requests for one DRAM channel that several cores share. Requests arrive on a valid/ready input stream. Each request carries an application identifier, a bank number and a row address, and it waits in a small queue. On every cycle the block offers one queued request on a valid/ready output stream. It also remembers which row was opened last in each of the channel's banks, so it can tell whether a request would hit that row or miss it.

Applications are not ranked. Each one sits in one of two classes: normal or demoted. The block counts how many grants in a row go to the same application. When that run reaches a configured threshold, the application is demoted. A free-running timer returns every application to the normal class at a configured interval. The output order depends on three things, in this order: class, then row hit, then age.

Back-pressure follows the usual stream rules. A request is accepted when in_valid and in_ready are both high on a rising clock edge. in_ready is low only while the queue is full. A request leaves the queue only when out_valid and out_ready are both high on a rising clock edge. While out_ready is low, out_valid stays high. The request on offer may still change to a higher-priority one, for example when a new request arrives or when a demotion is cleared.

Top module: `bls_sched`

## Requirements
- R1: When both classes have queued requests, a request from a normal-class application is offered before any request from a demoted application, even if the demoted request is older or hits an open row.
- R2: Among requests of the same class, a request whose row equals the open row of its bank (out_hit=1) is offered before a request that misses.
- R3: Among requests that tie on class and hit, the one that was enqueued earliest is offered first. If ages are equal, the lowest queue slot wins.
- R4: Each grant to the same application as the previous grant adds one to a streak. A grant to a different application restarts the streak at 1. The grant that brings the streak up to cfg_streak demotes that application. Demotion happens only on a grant.
- R5: Every cfg_period clock cycles, all demotions are cleared at once. A value of 0 or 1 clears on every cycle. If a clear and a demotion fall on the same cycle, the clear wins.
- R6: Issuing a request makes its row the open row of its bank. out_hit reports whether the offered request matches that bank's open row.
- R7: With an empty queue, out_valid is low. Idle cycles neither end nor extend the streak.
- R8: Once out_valid is high and out_ready is low, out_valid stays high. Queued requests are removed only by an output handshake, one per cycle.
- R9: in_ready is low exactly when QDEPTH requests are queued. A request accepted on one edge is offered or queued from the next cycle onward.
- R10: After reset, the queue is empty (out_valid=0, in_ready=1), no application is demoted, and no bank has an open row, so the first request to any bank misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request offered for enqueue |
| in_ready | output | 1 | Queue has a free slot |
| in_app | input | 2 | Application identifier of the request |
| in_bank | input | 3 | Target bank (8 banks) |
| in_row | input | 8 | Target row |
| out_valid | output | 1 | A request is offered for issue |
| out_ready | input | 1 | Channel accepts the offered request |
| out_app | output | 2 | Application of the offered request |
| out_bank | output | 3 | Bank of the offered request |
| out_row | output | 8 | Row of the offered request |
| out_hit | output | 1 | Offered request matches its bank's open row |
| cfg_streak | input | 4 | Run length of grants that demotes an application |
| cfg_period | input | 16 | Interval in cycles between demotion clears |

## Verification
A wrong streak count or a wrong demotion bit is not visible at once. It shows up only later, as a change in output order, the first time a demoted and a normal request compete. For that reason, every demotion scenario finishes with a head-to-head pair that must come out in a known order. A stale open-row entry shows up on the very next issue to that bank, as a wrong out_hit value, and often as a wrong order as well. A queue that loses or duplicates slots shows up when a full queue is drained: an entry comes out missing or out of enqueue order.

// File: rtl/bls_pkg.sv
package bls_pkg;
  localparam int APP_W     = 2;
  localparam int BANK_W    = 3;
  localparam int ROW_W     = 8;
  localparam int NUM_APPS  = 1 << APP_W;
  localparam int NUM_BANKS = 1 << BANK_W;

  typedef struct packed {
    logic [APP_W-1:0]  app;
    logic [BANK_W-1:0] bank;
    logic [ROW_W-1:0]  row;
  } req_t;
endpackage

// File: rtl/bls_queue.sv
module bls_queue
  import bls_pkg::*;
#(
  parameter int QDEPTH = 8,
  parameter int AGE_W  = 8,
  localparam int IDX_W = $clog2(QDEPTH)
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           push,
  input  req_t                           push_req,
  input  logic                           pop,
  input  logic [IDX_W-1:0]               pop_idx,
  output logic [QDEPTH-1:0]              vld,
  output req_t [QDEPTH-1:0]              ent,
  output logic [QDEPTH-1:0][AGE_W-1:0]   age,
  output logic                           full
);
  localparam logic [AGE_W-1:0] AGE_MAX = '1;

  logic [IDX_W-1:0] free_idx;
  logic             free_found;

  always_comb begin
    free_idx   = '0;
    free_found = 1'b0;
    for (int i = 0; i < QDEPTH; i++) begin
      if (!vld[i] && !free_found) begin
        free_idx   = IDX_W'(i);
        free_found = 1'b1;
      end
    end
  end

  assign full = &vld;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld <= '0;
      ent <= '0;
      age <= '0;
    end else begin
      for (int i = 0; i < QDEPTH; i++) begin
        if (vld[i] && age[i] != AGE_MAX) age[i] <= age[i] + 1'b1;
        if (pop && pop_idx == IDX_W'(i)) vld[i] <= 1'b0;
        if (push && !full && free_idx == IDX_W'(i)) begin
          vld[i] <= 1'b1;
          ent[i] <= push_req;
          age[i] <= '0;
        end
      end
    end
  end
endmodule

// File: rtl/bls_pick.sv
module bls_pick
  import bls_pkg::*;
#(
  parameter int QDEPTH = 8,
  parameter int AGE_W  = 8,
  localparam int IDX_W = $clog2(QDEPTH),
  localparam int KEY_W = AGE_W + 2
) (
  input  logic [QDEPTH-1:0]            vld,
  input  req_t [QDEPTH-1:0]            ent,
  input  logic [QDEPTH-1:0][AGE_W-1:0] age,
  input  logic [NUM_APPS-1:0]          blk,
  input  logic                         open_vld [NUM_BANKS],
  input  logic [ROW_W-1:0]             open_row [NUM_BANKS],
  output logic                         any,
  output logic [IDX_W-1:0]             sel,
  output logic                         sel_hit
);
  logic [QDEPTH-1:0] hit;
  logic [KEY_W-1:0]  key [QDEPTH];

  for (genvar g = 0; g < QDEPTH; g++) begin : g_key
    assign hit[g] = open_vld[ent[g].bank] && (open_row[ent[g].bank] == ent[g].row);
    assign key[g] = {~blk[ent[g].app], hit[g], age[g]};
  end

  logic [KEY_W-1:0] best;

  always_comb begin
    any     = 1'b0;
    sel     = '0;
    sel_hit = 1'b0;
    best    = '0;
    for (int i = 0; i < QDEPTH; i++) begin
      if (vld[i] && (!any || key[i] > best)) begin
        any     = 1'b1;
        sel     = IDX_W'(i);
        sel_hit = hit[i];
        best    = key[i];
      end
    end
  end
endmodule

// File: rtl/bls_track.sv
module bls_track
  import bls_pkg::*;
#(
  parameter int STRK_W = 4,
  parameter int PER_W  = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 grant,
  input  logic [APP_W-1:0]     grant_app,
  input  logic [STRK_W-1:0]    cfg_thr,
  input  logic [PER_W-1:0]     cfg_per,
  output logic [NUM_APPS-1:0]  blk
);
  localparam logic [STRK_W-1:0] STRK_MAX = '1;

  logic [APP_W-1:0]  last_app;
  logic              have_last;
  logic [STRK_W-1:0] streak, nxt_streak;
  logic [PER_W-1:0]  per_cnt;
  logic              clr_now;

  always_comb begin
    if (have_last && grant_app == last_app)
      nxt_streak = (streak == STRK_MAX) ? streak : streak + 1'b1;
    else
      nxt_streak = STRK_W'(1);
  end

  assign clr_now = (cfg_per <= PER_W'(1)) || (per_cnt >= cfg_per - 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      last_app  <= '0;
      have_last <= 1'b0;
      streak    <= '0;
      per_cnt   <= '0;
      blk       <= '0;
    end else begin
      per_cnt <= clr_now ? '0 : per_cnt + 1'b1;
      if (grant) begin
        last_app  <= grant_app;
        have_last <= 1'b1;
        streak    <= nxt_streak;
      end
      if (clr_now) blk <= '0;
      else if (grant && nxt_streak >= cfg_thr) blk[grant_app] <= 1'b1;
    end
  end
endmodule

// File: rtl/bls_sched.sv
module bls_sched
  import bls_pkg::*;
#(
  parameter int QDEPTH = 8,
  parameter int AGE_W  = 8,
  parameter int STRK_W = 4,
  parameter int PER_W  = 16,
  localparam int IDX_W = $clog2(QDEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [APP_W-1:0]  in_app,
  input  logic [BANK_W-1:0] in_bank,
  input  logic [ROW_W-1:0]  in_row,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [APP_W-1:0]  out_app,
  output logic [BANK_W-1:0] out_bank,
  output logic [ROW_W-1:0]  out_row,
  output logic              out_hit,
  input  logic [STRK_W-1:0] cfg_streak,
  input  logic [PER_W-1:0]  cfg_period
);
  logic [QDEPTH-1:0]            vld_q;
  req_t [QDEPTH-1:0]            ent_q;
  logic [QDEPTH-1:0][AGE_W-1:0] age_q;
  logic                         full_q;
  logic [NUM_APPS-1:0]          blk_q;
  logic                         open_vld [NUM_BANKS];
  logic [ROW_W-1:0]             open_row [NUM_BANKS];
  logic                         any_s, hit_s, grant, push;
  logic [IDX_W-1:0]             sel_s;
  req_t                         in_req, sel_req;

  assign in_req    = '{app: in_app, bank: in_bank, row: in_row};
  assign in_ready  = !full_q;
  assign push      = in_valid && in_ready;
  assign sel_req   = ent_q[sel_s];
  assign out_valid = any_s;
  assign out_app   = sel_req.app;
  assign out_bank  = sel_req.bank;
  assign out_row   = sel_req.row;
  assign out_hit   = hit_s;
  assign grant     = out_valid && out_ready;

  bls_queue #(.QDEPTH(QDEPTH), .AGE_W(AGE_W)) u_q (
    .clk(clk), .rst_n(rst_n), .push(push), .push_req(in_req),
    .pop(grant), .pop_idx(sel_s), .vld(vld_q), .ent(ent_q), .age(age_q), .full(full_q)
  );

  bls_pick #(.QDEPTH(QDEPTH), .AGE_W(AGE_W)) u_pick (
    .vld(vld_q), .ent(ent_q), .age(age_q), .blk(blk_q),
    .open_vld(open_vld), .open_row(open_row),
    .any(any_s), .sel(sel_s), .sel_hit(hit_s)
  );

  bls_track #(.STRK_W(STRK_W), .PER_W(PER_W)) u_trk (
    .clk(clk), .rst_n(rst_n), .grant(grant), .grant_app(sel_req.app),
    .cfg_thr(cfg_streak), .cfg_per(cfg_period), .blk(blk_q)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        open_vld[b] <= 1'b0;
        open_row[b] <= '0;
      end else if (grant && sel_req.bank == BANK_W'(b)) begin
        open_vld[b] <= 1'b1;
        open_row[b] <= sel_req.row;
      end
    end
  end
endmodule

// File: rtl/bls_sched_chk.sv
module bls_sched_chk
  import bls_pkg::*;
#(
  parameter int QDEPTH = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                in_valid,
  input logic                in_ready,
  input logic                out_valid,
  input logic                out_ready,
  input logic [APP_W-1:0]    out_app,
  input logic                out_hit,
  input logic [QDEPTH-1:0]   vld,
  input req_t [QDEPTH-1:0]   ent,
  input logic [NUM_APPS-1:0] blk,
  input logic                open_vld [NUM_BANKS],
  input logic [ROW_W-1:0]    open_row [NUM_BANKS]
);
  logic any_clean, peer_hit;

  always_comb begin
    any_clean = 1'b0;
    peer_hit  = 1'b0;
    for (int i = 0; i < QDEPTH; i++) begin
      if (vld[i] && !blk[ent[i].app]) any_clean = 1'b1;
      if (vld[i] && blk[ent[i].app] == blk[out_app] &&
          open_vld[ent[i].bank] && open_row[ent[i].bank] == ent[i].row)
        peer_hit = 1'b1;
    end
  end

  a_r1_clean_first: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && blk[out_app] |-> !any_clean);

  a_r2_hit_first: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_hit |-> !peer_hit);

  a_r4_demote_on_grant: assert property (@(posedge clk) disable iff (!rst_n)
    |(blk & ~$past(blk)) |-> $past(out_valid && out_ready));

  a_r7_idle_stays_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid && !(in_valid && in_ready) |=> !out_valid);

  a_r8_valid_held: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid);

  a_r9_push_visible: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);
endmodule

bind bls_sched bls_sched_chk #(.QDEPTH(QDEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_app(out_app), .out_hit(out_hit),
  .vld(vld_q), .ent(ent_q), .blk(blk_q), .open_vld(open_vld), .open_row(open_row)
);

// File: tb/sim_bls_sched.sv
module sim_bls_sched;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0, in_ready;
  logic [1:0] in_app = '0;
  logic [2:0] in_bank = '0;
  logic [7:0] in_row = '0;
  logic       out_valid, out_ready = 1'b0;
  logic [1:0] out_app;
  logic [2:0] out_bank;
  logic [7:0] out_row;
  logic       out_hit;
  logic [3:0] cfg_streak = 4'd3;
  logic [15:0] cfg_period = 16'd10000;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  logic [13:0] exp_q[$];
  string       tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  bls_sched u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_app(in_app), .in_bank(in_bank), .in_row(in_row),
    .out_valid(out_valid), .out_ready(out_ready), .out_app(out_app),
    .out_bank(out_bank), .out_row(out_row), .out_hit(out_hit),
    .cfg_streak(cfg_streak), .cfg_period(cfg_period)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", checks, fails);
      $finish;
    end
  endtask

  task automatic enq(input int app, input int bank, input int row);
    @(posedge clk); #1;
    in_valid = 1'b1; in_app = 2'(app); in_bank = 3'(bank); in_row = 8'(row);
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  task automatic expect_item(input int app, input int bank, input int row, input int hit, input string tag);
    exp_q.push_back({2'(app), 3'(bank), 8'(row), 1'(hit)});
    tag_q.push_back(tag);
  endtask

  task automatic go();
    @(posedge clk); #1;
    out_ready = 1'b1;
    while (exp_q.size() != 0) @(posedge clk);
    #1 out_ready = 1'b0;
  endtask

  // monitor: compares each handshake against the scoreboard
  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R8 unexpected grant", int'({out_app, out_bank, out_row}), -1);
      end else begin
        logic [13:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk({out_app, out_bank, out_row, out_hit} == e, t,
            int'({out_app, out_bank, out_row, out_hit}), int'(e));
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R10 out_valid after reset", out_valid, 0);
    chk(in_ready == 1'b1, "R10 in_ready after reset", in_ready, 1);

    // R10/R6: first access to a bank misses
    enq(1, 0, 3);
    expect_item(1, 0, 3, 0, "R10 first access misses");
    go();

    // R2: younger hit beats older miss; R8 valid held
    enq(2, 0, 7);
    enq(3, 0, 3);
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(out_valid == 1'b1, "R8 valid held under back-pressure", out_valid, 1);
    expect_item(3, 0, 3, 1, "R2 hit first");
    expect_item(2, 0, 7, 0, "R2 miss second");
    go();

    // R6: bank 0 open row is now 7
    enq(0, 0, 7);
    expect_item(0, 0, 7, 1, "R6 open row updated by miss");
    go();

    // R3: equal class and miss, oldest first
    enq(2, 1, 1);
    enq(3, 2, 1);
    expect_item(2, 1, 1, 0, "R3 oldest first");
    expect_item(3, 2, 1, 0, "R3 younger second");
    go();

    // R4 + R7: app0 streak of 3 across idle gaps demotes it
    enq(0, 3, 9); expect_item(0, 3, 9, 0, "R4 streak grant 1"); go();
    repeat (20) @(posedge clk);
    @(negedge clk); chk(out_valid == 1'b0, "R7 idle no valid", out_valid, 0);
    enq(0, 3, 9); expect_item(0, 3, 9, 1, "R4 streak grant 2"); go();
    repeat (20) @(posedge clk);
    @(negedge clk); chk(out_valid == 1'b0, "R7 idle no valid", out_valid, 0);
    enq(0, 3, 9); expect_item(0, 3, 9, 1, "R7 streak kept over idle"); go();

    // R1: demoted older hit loses to normal miss
    enq(0, 3, 9);
    enq(1, 4, 2);
    expect_item(1, 4, 2, 0, "R1 normal miss first");
    expect_item(0, 3, 9, 1, "R1 demoted hit last");
    go();

    // R4: streak restarts on a different application
    enq(2, 5, 4); expect_item(2, 5, 4, 0, "R4 run"); go();
    enq(2, 5, 4); expect_item(2, 5, 4, 1, "R4 run"); go();
    enq(1, 6, 1); expect_item(1, 6, 1, 0, "R4 break"); go();
    enq(2, 5, 4); expect_item(2, 5, 4, 1, "R4 restart"); go();
    enq(2, 5, 4); expect_item(2, 5, 4, 1, "R4 restart"); go();
    enq(2, 7, 1);
    enq(1, 6, 5);
    expect_item(2, 7, 1, 0, "R4 not demoted after restart");
    expect_item(1, 6, 5, 0, "R4 pair second");
    go();

    // R5: demote app3, confirm, then clear via short period
    enq(3, 0, 2); expect_item(3, 0, 2, 0, "R4 run"); go();
    enq(3, 0, 2); expect_item(3, 0, 2, 1, "R4 run"); go();
    enq(3, 0, 2); expect_item(3, 0, 2, 1, "R4 run"); go();
    enq(3, 1, 8);
    enq(1, 2, 8);
    expect_item(1, 2, 8, 0, "R1 app3 demoted");
    expect_item(3, 1, 8, 0, "R1 app3 last");
    go();
    cfg_period = 16'd50;
    repeat (60) @(posedge clk);
    #1 cfg_period = 16'd10000;
    enq(3, 1, 9);
    enq(1, 2, 9);
    expect_item(3, 1, 9, 0, "R5 demotion cleared");
    expect_item(1, 2, 9, 0, "R5 pair second");
    go();

    // R9 + R8: fill the queue, then drain in enqueue order
    for (int k = 0; k < 8; k++) enq(1, 7, 10 + k);
    @(negedge clk);
    chk(in_ready == 1'b0, "R9 in_ready low when full", in_ready, 0);
    chk(out_valid == 1'b1, "R8 valid while full", out_valid, 1);
    for (int k = 0; k < 8; k++) expect_item(1, 7, 10 + k, 0, "R8 drain order");
    go();
    @(negedge clk);
    chk(in_ready == 1'b1, "R9 in_ready after drain", in_ready, 1);
    chk(out_valid == 1'b0, "R7 empty after drain", out_valid, 0);

    finish_run();
  end
endmodule